// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes one of two SDRAM devices from power-up to normal operation. A start pulse picks the device by index and samples the CAS latency and refresh count. The sequencer then drives the SDRAM command pins through a fixed sequence: clock enable, a power-up wait, precharge-all, a run of auto-refresh commands, load mode register, and the return to normal mode. Every wait between steps is counted in controller clock cycles.

Each step also appears as a strobed command word. The word carries the step's mode code and one target bit for each device. The auto-refresh word adds a repeat field, and the load-mode word adds the mode-register value. Busy stays high while any step is still running, and a new start is not accepted until busy clears. At the end, done rises and a refresh timer loads from the programmed count and starts requesting periodic refreshes.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, busy, done, CKE, the refresh request and the command strobe are low, and both chip selects are high.
- R2: A start with device index 0 or 1 makes busy high in the next cycle. A start with index 2 or 3 is ignored: busy stays low, no command word is strobed, and done keeps its value.
- R3: A start that arrives while busy is high is ignored. The running sequence keeps its device and its CAS latency.
- R4: Command word bits [2:0] hold the mode code: 0 normal, 1 clock enable, 2 precharge, 3 auto-refresh, 4 load mode register. Bit 4 is set when device 0 is the target and bit 3 is set when device 1 is the target.
- R5: Exactly five words are strobed, one per cycle, with modes in the order 1, 2, 3, 4, 0.
- R6: CKE is high in the cycle after the clock-enable word. Precharge is issued exactly CLK_MHZ*PWRUP_US+1 cycles after the clock-enable word, and every pin command in between is NOP (RAS/CAS/WE = 1/1/1).
- R7: Precharge-all drives RAS/CAS/WE = 0/1/0 with address bit 10 high and all other address bits low. The first auto-refresh follows T_RP+1 cycles later.
- R8: AREF_NUM auto-refresh pin commands (RAS/CAS/WE = 0/0/1) are issued, spaced T_RC+1 cycles apart. The auto-refresh word's field [8:5] holds AREF_NUM-1.
- R9: Load mode register drives RAS/CAS/WE = 0/0/0 with the address carrying the CAS latency in bits [6:4] and burst length 0 in bits [2:0]. The same value appears in word bits [9 +: ADDR_W].
- R10: Done rises on the same edge on which busy falls. It stays high until the next accepted start, which clears it in the following cycle.
- R11: The refresh request is a one-cycle pulse. The first pulse comes 2*count cycles after done rises, and later pulses come every 2*count+1 cycles.
- R12: Only the selected device's chip select goes low. The other device's chip select stays high for the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| dev_idx_i | input | 2 | Target device index; only 0 and 1 are valid |
| cas_lat_i | input | 3 | CAS latency written into the mode register |
| ref_count_i | input | REF_W | Refresh count; the timer reloads with twice this value |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | The sequence has finished |
| refresh_req_o | output | 1 | Periodic refresh request pulse |
| cmd_stb_o | output | 1 | A command word is valid this cycle |
| cmd_word_o | output | 9+ADDR_W | Command word |
| sd_cke_o | output | 1 | SDRAM clock enable |
| sd_cs_n_o | output | 2 | Chip selects, one per device, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_ba_o | output | 2 | Bank address |
| sd_addr_o | output | ADDR_W | Address bus |

## Verification
The bench measures the power-up wait and every command gap to the exact cycle. A wait counter that is off by one would shift precharge or the auto-refresh spacing, and the measured distance would not match. It injects a start in the middle of a run and uses illegal device indices; a design that latched either would strobe words for the wrong device or pull the other chip select low. It counts the auto-refresh pin commands and decodes the repeat and mode-register fields, which catches a sequencer that loops the wrong number of times or places the CAS latency at the wrong bit. It also times two refresh pulses after done, which exposes a reload value that is not doubled or a request held longer than one cycle.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL    = 3'd0,
    MODE_CLK_EN    = 3'd1,
    MODE_PRECHARGE = 3'd2,
    MODE_AREF      = 3'd3,
    MODE_LOAD_MR   = 3'd4,
    MODE_SELF_REF  = 3'd5,
    MODE_PWR_DOWN  = 3'd6
  } cmd_mode_e;

  typedef enum logic [1:0] {
    PIN_NOP,
    PIN_PRE,
    PIN_AREF,
    PIN_LMR
  } pin_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CKE,
    S_PWAIT,
    S_PRE,
    S_TRP,
    S_AREF,
    S_TRC,
    S_LMR,
    S_TMRD,
    S_NORM
  } seq_state_e;

  localparam int TGT_DEV0_BIT = 4;
  localparam int TGT_DEV1_BIT = 3;
  localparam int REP_LSB      = 5;
  localparam int REP_W        = 4;
  localparam int MRV_LSB      = 9;
  localparam int NDEV         = 2;

endpackage

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = val_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int REF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic [REF_W-1:0] count_i,
  output logic             req_o
);

  localparam int CW = REF_W + 1;

  logic [CW-1:0] cnt_q, cnt_d, rel_q, rel_d;
  logic          run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    rel_d = rel_q;
    run_d = run_q;
    if (stop_i) begin
      run_d = 1'b0;
    end else if (load_i) begin
      rel_d = {count_i, 1'b0};
      cnt_d = {count_i, 1'b0};
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) cnt_d = rel_q;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
      run_q <= run_d;
    end
  end

  assign req_o = run_q && (cnt_q == '0);

  AST_REF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && rel_q != '0 && !load_i && !stop_i) |=> !req_o); // R11

  AST_REF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !load_i && !stop_i) |=> (cnt_q == $past(rel_q))); // R11

endmodule

// File: rtl/sdram_cmd_pins.sv
module sdram_cmd_pins
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              active_i,
  input  logic              dev_i,
  input  pin_cmd_e          pin_cmd_i,
  input  logic [ADDR_W-1:0] mode_val_i,
  output logic [NDEV-1:0]   cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  for (genvar g = 0; g < NDEV; g++) begin : g_cs
    assign cs_n_o[g] = !(active_i && (dev_i == 1'(g)));
  end

  always_comb begin
    ras_n_o = 1'b1;
    cas_n_o = 1'b1;
    we_n_o  = 1'b1;
    addr_o  = '0;
    ba_o    = 2'b00;
    if (active_i) begin
      unique case (pin_cmd_i)
        PIN_PRE: begin
          ras_n_o    = 1'b0;
          we_n_o     = 1'b0;
          addr_o[10] = 1'b1;
        end
        PIN_AREF: begin
          ras_n_o = 1'b0;
          cas_n_o = 1'b0;
        end
        PIN_LMR: begin
          ras_n_o = 1'b0;
          cas_n_o = 1'b0;
          we_n_o  = 1'b0;
          addr_o  = mode_val_i;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int PWR_CYC  = 20000,
  parameter int T_RP     = 3,
  parameter int T_RC     = 8,
  parameter int T_MRD    = 2,
  parameter int AREF_NUM = 8,
  parameter int ADDR_W   = 13,
  parameter int REF_W    = 16,
  parameter int TW       = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [1:0]                dev_idx_i,
  input  logic [2:0]                cas_lat_i,
  input  logic [REF_W-1:0]          ref_count_i,
  input  logic                      tmr_zero_i,
  output logic                      tmr_load_o,
  output logic [TW-1:0]             tmr_val_o,
  output logic                      accept_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      cke_o,
  output logic                      in_wait_o,
  output logic                      dev_o,
  output pin_cmd_e                  pin_cmd_o,
  output logic [ADDR_W-1:0]         mode_val_o,
  output logic                      ref_load_o,
  output logic [REF_W-1:0]          ref_val_o,
  output logic                      cmd_stb_o,
  output logic [MRV_LSB+ADDR_W-1:0] cmd_word_o
);

  localparam int AW = $clog2(AREF_NUM + 1);

  seq_state_e        state_q, state_d;
  logic [AW-1:0]     aref_q, aref_d;
  logic              done_q, done_d;
  logic              cke_q, cke_d;
  logic              dev_q;
  logic [2:0]        cas_q;
  logic [REF_W-1:0]  ref_q;
  cmd_mode_e         mode;
  logic              accept;

  assign accept = (state_q == S_IDLE) && start_i && (dev_idx_i < 2'd2);

  always_comb begin
    state_d    = state_q;
    aref_d     = aref_q;
    done_d     = done_q;
    cke_d      = cke_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    cmd_stb_o  = 1'b0;
    mode       = MODE_NORMAL;
    pin_cmd_o  = PIN_NOP;
    ref_load_o = 1'b0;
    unique case (state_q)
      S_IDLE: if (accept) begin
        state_d = S_CKE;
        done_d  = 1'b0;
        aref_d  = '0;
      end
      S_CKE: begin
        cmd_stb_o  = 1'b1;
        mode       = MODE_CLK_EN;
        cke_d      = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(PWR_CYC - 1);
        state_d    = S_PWAIT;
      end
      S_PWAIT: if (tmr_zero_i) state_d = S_PRE;
      S_PRE: begin
        cmd_stb_o  = 1'b1;
        mode       = MODE_PRECHARGE;
        pin_cmd_o  = PIN_PRE;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(T_RP - 1);
        state_d    = S_TRP;
      end
      S_TRP: if (tmr_zero_i) state_d = S_AREF;
      S_AREF: begin
        cmd_stb_o  = (aref_q == '0);
        mode       = MODE_AREF;
        pin_cmd_o  = PIN_AREF;
        aref_d     = aref_q + 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(T_RC - 1);
        state_d    = S_TRC;
      end
      S_TRC: if (tmr_zero_i)
        state_d = (aref_q == AW'(AREF_NUM)) ? S_LMR : S_AREF;
      S_LMR: begin
        cmd_stb_o  = 1'b1;
        mode       = MODE_LOAD_MR;
        pin_cmd_o  = PIN_LMR;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(T_MRD - 1);
        state_d    = S_TMRD;
      end
      S_TMRD: if (tmr_zero_i) state_d = S_NORM;
      S_NORM: begin
        cmd_stb_o  = 1'b1;
        mode       = MODE_NORMAL;
        done_d     = 1'b1;
        ref_load_o = 1'b1;
        state_d    = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      aref_q  <= '0;
      done_q  <= 1'b0;
      cke_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      aref_q  <= aref_d;
      done_q  <= done_d;
      cke_q   <= cke_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q <= 1'b0;
      cas_q <= '0;
      ref_q <= '0;
    end else if (accept) begin
      dev_q <= dev_idx_i[0];
      cas_q <= cas_lat_i;
      ref_q <= ref_count_i;
    end
  end

  always_comb begin
    mode_val_o      = '0;
    mode_val_o[6:4] = cas_q;
  end

  always_comb begin
    cmd_word_o               = '0;
    cmd_word_o[2:0]          = mode;
    cmd_word_o[TGT_DEV0_BIT] = (dev_q == 1'b0);
    cmd_word_o[TGT_DEV1_BIT] = (dev_q == 1'b1);
    if (mode == MODE_AREF)
      cmd_word_o[REP_LSB +: REP_W] = REP_W'(AREF_NUM - 1);
    if (mode == MODE_LOAD_MR)
      cmd_word_o[MRV_LSB +: ADDR_W] = mode_val_o;
  end

  assign accept_o  = accept;
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign cke_o     = cke_q;
  assign in_wait_o = (state_q == S_PWAIT);
  assign dev_o     = dev_q;
  assign ref_val_o = ref_q;

  // checker: cycles spent in the power-up wait of the current run
  logic [TW-1:0] pw_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                           pw_cnt_q <= '0;
    else if (state_q == S_CKE)                            pw_cnt_q <= '0;
    else if (state_q == S_PWAIT && pw_cnt_q != {TW{1'b1}}) pw_cnt_q <= pw_cnt_q + 1'b1;
  end

  AST_PRE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PRE) |-> (pw_cnt_q >= TW'(PWR_CYC))); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(dev_q) && $stable(cas_q))); // R3

  AST_LMR_AFTER_AREFS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LMR) |-> (aref_q == AW'(AREF_NUM))); // R8

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int PWRUP_US = 200,
  parameter int T_RP     = 3,
  parameter int T_RC     = 8,
  parameter int T_MRD    = 2,
  parameter int AREF_NUM = 8,
  parameter int ADDR_W   = 13,
  parameter int REF_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [1:0]                dev_idx_i,
  input  logic [2:0]                cas_lat_i,
  input  logic [REF_W-1:0]          ref_count_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      refresh_req_o,
  output logic                      cmd_stb_o,
  output logic [MRV_LSB+ADDR_W-1:0] cmd_word_o,
  output logic                      sd_cke_o,
  output logic [1:0]                sd_cs_n_o,
  output logic                      sd_ras_n_o,
  output logic                      sd_cas_n_o,
  output logic                      sd_we_n_o,
  output logic [1:0]                sd_ba_o,
  output logic [ADDR_W-1:0]         sd_addr_o
);

  localparam int PWR_CYC = CLK_MHZ * PWRUP_US;
  localparam int TW      = $clog2(PWR_CYC + T_RP + T_RC + T_MRD + 1);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              tmr_load, tmr_zero, accept, in_wait, dev, ref_load;
  logic [TW-1:0]     tmr_val;
  pin_cmd_e          pin_cmd;
  logic [ADDR_W-1:0] mode_val;
  logic [REF_W-1:0]  ref_val;

  sdram_init_fsm #(
    .PWR_CYC(PWR_CYC), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD),
    .AREF_NUM(AREF_NUM), .ADDR_W(ADDR_W), .REF_W(REF_W), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i), .dev_idx_i(dev_idx_i),
    .cas_lat_i(cas_lat_i), .ref_count_i(ref_count_i), .tmr_zero_i(tmr_zero),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .accept_o(accept),
    .busy_o(busy_o), .done_o(done_o), .cke_o(sd_cke_o), .in_wait_o(in_wait),
    .dev_o(dev), .pin_cmd_o(pin_cmd), .mode_val_o(mode_val),
    .ref_load_o(ref_load), .ref_val_o(ref_val), .cmd_stb_o(cmd_stb_o),
    .cmd_word_o(cmd_word_o)
  );

  sdram_wait_timer #(.TW(TW)) u_wait (
    .clk(clk), .rst_n(rst_int_n), .load_i(tmr_load), .val_i(tmr_val),
    .zero_o(tmr_zero)
  );

  sdram_refresh_timer #(.REF_W(REF_W)) u_refresh (
    .clk(clk), .rst_n(rst_int_n), .load_i(ref_load), .stop_i(accept),
    .count_i(ref_val), .req_o(refresh_req_o)
  );

  sdram_cmd_pins #(.ADDR_W(ADDR_W)) u_pins (
    .active_i(busy_o), .dev_i(dev), .pin_cmd_i(pin_cmd), .mode_val_i(mode_val),
    .cs_n_o(sd_cs_n_o), .ras_n_o(sd_ras_n_o), .cas_n_o(sd_cas_n_o),
    .we_n_o(sd_we_n_o), .ba_o(sd_ba_o), .addr_o(sd_addr_o)
  );

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(busy_o && done_o)); // R10

  AST_NOP_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_wait |-> ({sd_ras_n_o, sd_cas_n_o, sd_we_n_o} == 3'b111 && sd_cke_o)); // R6

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones(~sd_cs_n_o) <= 1); // R12

  AST_BAD_INDEX: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_o && start_i && dev_idx_i[1]) |=> !busy_o); // R2

endmodule

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

  localparam int CLK_MHZ = 1, PWRUP_US = 200, T_RP = 2, T_RC = 4, T_MRD = 2;
  localparam int AREF_NUM = 8, ADDR_W = 13, REF_W = 8;
  localparam int PWR = CLK_MHZ * PWRUP_US;
  localparam int WW = 9 + ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] dev_idx = 2'd0;
  logic [2:0] cas = 3'd0;
  logic [REF_W-1:0] refc = '0;
  logic busy, done, req, stb, cke, ras_n, cas_n, we_n;
  logic [WW-1:0] word;
  logic [1:0] cs_n, ba;
  logic [ADDR_W-1:0] addr;

  always #2.5 clk = ~clk;

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .T_RP(T_RP), .T_RC(T_RC),
    .T_MRD(T_MRD), .AREF_NUM(AREF_NUM), .ADDR_W(ADDR_W), .REF_W(REF_W)
  ) u_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dev_idx_i(dev_idx),
    .cas_lat_i(cas), .ref_count_i(refc), .busy_o(busy), .done_o(done),
    .refresh_req_o(req), .cmd_stb_o(stb), .cmd_word_o(word), .sd_cke_o(cke),
    .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n), .sd_cas_n_o(cas_n), .sd_we_n_o(we_n),
    .sd_ba_o(ba), .sd_addr_o(addr)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor state
  bit mon_on = 0;
  int other_dev = 1;
  int nw, na, nr, clk_cyc, pre_cyc, lmr_cyc, done_cyc, bad_cs, bad_nop;
  int cke_after, busy_at_done, pre_addr, lmr_addr;
  logic [WW-1:0] words[8];
  int aref_cyc[16];
  int req_cyc[4];

  task automatic mon_clear();
    nw = 0; na = 0; nr = 0; clk_cyc = -10; pre_cyc = -1; lmr_cyc = -1;
    done_cyc = -1; bad_cs = 0; bad_nop = 0; cke_after = -1; busy_at_done = 0;
    pre_addr = -1; lmr_addr = -1;
  endtask

  always @(negedge clk) if (mon_on) begin
    logic [2:0] c3;
    c3 = {ras_n, cas_n, we_n};
    if (stb) begin
      if (nw < 8) words[nw] = word;
      nw++;
      if (word[2:0] == 3'd1 && clk_cyc < 0) clk_cyc = cyc;
    end
    if (clk_cyc >= 0 && cyc == clk_cyc + 1) cke_after = int'(cke);
    if (!cs_n[other_dev]) bad_cs++;
    if (c3 == 3'b010 && pre_cyc < 0) begin
      pre_cyc = cyc; pre_addr = int'(addr);
    end else if (busy && clk_cyc >= 0 && cyc > clk_cyc && pre_cyc < 0 && c3 != 3'b111)
      bad_nop++;
    if (c3 == 3'b001 && na < 16) begin aref_cyc[na] = cyc; na++; end
    if (c3 == 3'b000 && lmr_cyc < 0) begin lmr_cyc = cyc; lmr_addr = int'(addr); end
    if (done && clk_cyc >= 0 && done_cyc < 0) begin
      done_cyc = cyc; busy_at_done = int'(busy);
    end
    if (req && done_cyc >= 0 && cyc > done_cyc && nr < 4) begin
      req_cyc[nr] = cyc; nr++;
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && cke == 0, "R1 busy/done/cke", {busy, done, cke}, 0);
    chk(cs_n == 2'b11, "R1 cs_n", cs_n, 3);
    chk(req == 0 && stb == 0, "R1 req/stb", {req, stb}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 after release", {busy, done}, 0);
  endtask

  task automatic t_init(input int dv, input int cl, input int rc, input bit inject);
    logic [WW-1:0] tgt, exp_w[5];
    int gap;
    bit ok;
    tgt = (dv == 0) ? WW'(1 << 4) : WW'(1 << 3);
    exp_w[0] = tgt | WW'(1);
    exp_w[1] = tgt | WW'(2);
    exp_w[2] = tgt | WW'(3) | WW'((AREF_NUM - 1) << 5);
    exp_w[3] = tgt | WW'(4) | WW'((cl << 4) << 9);
    exp_w[4] = tgt;
    other_dev = 1 - dv;
    dev_idx = 2'(dv); cas = 3'(cl); refc = REF_W'(rc); start = 1'b1;
    mon_clear(); mon_on = 1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1, "R2 busy after start", busy, 1);
    chk(done == 0, "R10 done cleared by start", done, 0);
    if (inject) begin
      repeat (20) @(negedge clk);
      dev_idx = 2'(1 - dv); cas = 3'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1, "R3 still busy after extra start", busy, 1);
    end
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    repeat (4 * rc + 8) @(negedge clk);
    mon_on = 0;
    chk(nw == 5, "R5 word count", nw, 5);
    for (int k = 0; k < 5; k++)
      chk(words[k] == exp_w[k], $sformatf("R4/R5/R8/R9 word %0d", k), words[k], exp_w[k]);
    chk(cke_after == 1, "R6 cke after clock enable", cke_after, 1);
    chk(pre_cyc - clk_cyc == PWR + 1, "R6 power-up wait", pre_cyc - clk_cyc, PWR + 1);
    chk(bad_nop == 0, "R6 NOP during wait", bad_nop, 0);
    chk(pre_addr == (1 << 10), "R7 precharge address", pre_addr, 1 << 10);
    chk(na == AREF_NUM, "R8 refresh count", na, AREF_NUM);
    chk(aref_cyc[0] - pre_cyc == T_RP + 1, "R7 precharge to refresh", aref_cyc[0] - pre_cyc, T_RP + 1);
    ok = 1; gap = 0;
    for (int k = 1; k < na && k < 16; k++)
      if (aref_cyc[k] - aref_cyc[k-1] != T_RC + 1) begin ok = 0; gap = aref_cyc[k] - aref_cyc[k-1]; end
    chk(ok, "R8 refresh spacing", gap, T_RC + 1);
    chk(lmr_addr == (cl << 4), "R9 mode register address", lmr_addr, cl << 4);
    chk(bad_cs == 0, "R12 other chip select", bad_cs, 0);
    chk(done_cyc >= 0 && busy_at_done == 0, "R10 busy falls with done", busy_at_done, 0);
    chk(done == 1, "R10 done held", done, 1);
    chk(nr >= 2, "R11 refresh pulses seen", nr, 2);
    chk(req_cyc[0] - done_cyc == 2 * rc, "R11 first refresh", req_cyc[0] - done_cyc, 2 * rc);
    chk(req_cyc[1] - req_cyc[0] == 2 * rc + 1, "R11 refresh period", req_cyc[1] - req_cyc[0], 2 * rc + 1);
  endtask

  task automatic t_reject(input int idx);
    bit was_done;
    was_done = done;
    @(negedge clk);
    dev_idx = 2'(idx); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 0 && stb == 0, $sformatf("R2 index %0d ignored", idx), {busy, stb}, 0);
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == was_done, "R2 state unchanged", {busy, done}, {1'b0, was_done});
  endtask

  initial begin
    t_reset();
    t_init(0, 2, 4, 1'b1);
    t_reject(2);
    t_reject(3);
    t_init(1, 3, 5, 1'b0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule